// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synchronous static RAM meant for the data side of a cache. It registers the address, write data and write/burst controls on the rising clock edge. The access array is built from one memory per byte lane, and read data leaves through an output register. A read therefore shows at the output after the second rising edge that follows the cycle in which it was requested. A burst of up to four words begins when either of two start strobes is raised together with the chip select. After that, each cycle with the step input high reaches the next word of the aligned four-word block. The next word comes from an internal 2-bit counter in either linear or interleaved order.

Writes take effect on the clock edge after they are captured. Any subset of the four byte lanes can be written, or the whole word at once. The processor-side strobe always starts a read. The controller-side strobe can start a read or a write. Raising a strobe with the chip select low ends the burst. The output-enable input gates the output at once, without waiting for a clock edge. While the sleep input is high, the block starts no new access and keeps its contents.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read requested in the cycle before rising edge E appears on `dout` with `dout_vld` high after edge E+1, and stays there until edge E+2.
- R2: Either `start_proc` or `start_ctrl` with `chip_sel` high loads `addr` as the burst base and accesses that word. `start_proc` takes priority when both are high.
- R3: A cycle with no strobe and `step` high, while a burst is active, accesses the next burst word. A cycle with neither a strobe nor `step` makes no access, and `dout_vld` is low one edge later.
- R4: With `order_ilv` = 0, the low two address bits of burst word k are (base + k) mod 4, and the upper bits stay those of the base.
- R5: With `order_ilv` = 1, the low two address bits of burst word k are base XOR k.
- R6: Lane i is bits 8i+7..8i. A lane is written only when `lane_en[i]` and `wr_en` are both high. A write cycle produces no read data. `lane_en` without `wr_en` gives a read.
- R7: `wr_all` high writes all four lanes, whatever the values of `wr_en` and `lane_en`.
- R8: In a cycle where `start_proc` is high, all write inputs are ignored and the access is a read.
- R9: A strobe with `chip_sel` low ends the burst. Later `step` cycles make no access until a new start.
- R10: `out_en` low forces `dout_vld` low and `dout` to zero within the same cycle, with no clock edge.
- R11: While `sleep` is high, no access or write occurs, the burst counter holds, and the memory keeps its contents.
- R12: While `rst_n` is low at a rising edge, `dout_vld` is low after that edge and any burst is ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded by a start strobe |
| start_proc | input | 1 | Processor-side burst start, always a read |
| start_ctrl | input | 1 | Controller-side burst start, read or write |
| chip_sel | input | 1 | Selects the device when a strobe is raised |
| step | input | 1 | Advance to the next burst word |
| order_ilv | input | 1 | Static order select: 0 linear, 1 interleaved |
| wr_en | input | 1 | Write enable that qualifies the lane enables |
| lane_en | input | 4 | Per-lane write enables |
| wr_all | input | 1 | Write all lanes |
| din | input | 32 | Write data |
| out_en | input | 1 | Asynchronous output gate |
| sleep | input | 1 | Blocks new accesses, keeps contents |
| dout | output | 32 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid and output enabled |

## Verification
The hardest state to reach is a burst that is active while the sleep input blocks the cycle in which it would have advanced. Only the word read after sleep ends shows that the counter held. The bench reaches this state by starting a read burst, raising sleep together with step for one cycle, and then stepping again. It then expects the word right after the base, not the one after that. A second hard case is interleaved order. It differs from linear order only for odd base offsets, so the bench starts that burst at offset 1 and checks that the words come in the order 1, 0, 3, 2.

// File: rtl/psram_pkg.sv
// Package: shared constants and the burst-order address function.
// Assumes a word made of LANES lanes of LANE_W bits each.
package psram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    // Low two address bits of burst word k, given the base low bits.
    function automatic logic [1:0] burst_low(input logic [1:0] base_lo,
                                             input logic [1:0] k,
                                             input burst_ord_e ord);
        return (ord == ORD_INTERLEAVE) ? (base_lo ^ k) : (base_lo + k);
    endfunction
endpackage

// File: rtl/burst_ctr.sv
// Burst address generator: keeps the base address and a 2-bit word count,
// and gives the address of the access made in the current cycle.
// Assumes load, adv and kill are mutually exclusive (the top ensures this).
module burst_ctr
    import psram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              kill,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nxt;
    logic [ADDR_W-1:0] base_nxt;
    burst_ord_e        ord;

    assign ord = ilv ? ORD_INTERLEAVE : ORD_LINEAR;

    // Address of this cycle's access: new base on load, next word on advance.
    always_comb begin
        cnt_nxt  = load ? 2'd0 : (cnt_q + 2'd1);
        base_nxt = load ? base_in : base_q;
        acc_addr = {base_nxt[ADDR_W-1:2], burst_low(base_nxt[1:0], cnt_nxt, ord)};
    end

    // Burst state: load on a start, step on an advance, clear on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            active <= 1'b0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= 2'd0;
            active <= 1'b1;
        end else if (kill) begin
            active <= 1'b0;
        end else if (adv) begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cnt_q == $past(cnt_q) + 2'd1));
    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv && !kill) |=> ($stable(cnt_q) && $stable(base_q)));
    // R9
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !active);
endmodule

// File: rtl/wr_lane_dec.sv
// Write lane decoder: merges the per-lane, qualifying and global write
// enables into one enable per lane. A read-only cycle masks them all.
module wr_lane_dec
    import psram_pkg::*;
(
    input  logic             wr_en,
    input  logic             wr_all,
    input  logic [LANES-1:0] lane_en,
    input  logic             read_only,
    output logic [LANES-1:0] lanes
);
    // Global write wins; otherwise the lane enables are qualified by wr_en.
    always_comb begin
        if (read_only)   lanes = '0;
        else if (wr_all) lanes = '1;
        else if (wr_en)  lanes = lane_en;
        else             lanes = '0;
    end
endmodule

// File: rtl/sram_core.sv
// Storage and output register: one memory per byte lane. Writes happen at the
// edge after capture; reads load the output register at that same edge.
// Assumes acc_* comes straight from the input-stage registers.
module sram_core
    import psram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [LANES-1:0]  acc_lanes,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_din,
    output logic [WORD_W-1:0] rd_q,
    output logic              rd_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] rd_word;
    logic              is_read;

    assign is_read = acc_vld && (acc_lanes == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Lane write, enabled for this lane only.
        always_ff @(posedge clk) begin
            if (acc_vld && acc_lanes[g])
                lane_mem[acc_addr] <= acc_din[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[acc_addr];
    end

    // Output register: data held until the next read, valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= is_read;
            if (is_read) rd_q <= rd_word;
        end
    end

    // R6
    wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_lanes != '0)) |=> !rd_vld);
    // R1
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_lanes == '0)) |=> rd_vld);
endmodule

// File: rtl/pipe_burst_sram.sv
// Top level: input-stage registers, strobe qualification and output gating
// around the burst counter, the lane decoder and the storage core.
// Assumes order_ilv changes only while no burst is running.
module pipe_burst_sram
    import psram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start_proc,
    input  logic              start_ctrl,
    input  logic              chip_sel,
    input  logic              step,
    input  logic              order_ilv,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic              wr_all,
    input  logic [WORD_W-1:0] din,
    input  logic              out_en,
    input  logic              sleep,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);
    logic              strobe, load, adv, kill, active;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_lanes;
    logic              acc_vld_q;
    logic [LANES-1:0]  acc_lanes_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [WORD_W-1:0] din_q;
    logic [WORD_W-1:0] rd_q;
    logic              rd_vld;

    // Strobe qualification: sleep blocks everything, chip_sel picks start or stop.
    always_comb begin
        strobe = start_proc || start_ctrl;
        load   = !sleep && strobe && chip_sel;
        kill   = !sleep && strobe && !chip_sel;
        adv    = !sleep && !strobe && step && active;
    end

    burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .kill     (kill),
        .ilv      (order_ilv),
        .base_in  (addr),
        .acc_addr (cur_addr),
        .active   (active)
    );

    wr_lane_dec i_dec (
        .wr_en     (wr_en),
        .wr_all    (wr_all),
        .lane_en   (lane_en),
        .read_only (start_proc),
        .lanes     (cur_lanes)
    );

    // Input stage: capture this cycle's access for the array at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vld_q   <= 1'b0;
            acc_lanes_q <= '0;
        end else begin
            acc_vld_q   <= load || adv;
            acc_lanes_q <= cur_lanes;
        end
        acc_addr_q <= cur_addr;
        din_q      <= din;
    end

    sram_core #(.ADDR_W(ADDR_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vld   (acc_vld_q),
        .acc_lanes (acc_lanes_q),
        .acc_addr  (acc_addr_q),
        .acc_din   (din_q),
        .rd_q      (rd_q),
        .rd_vld    (rd_vld)
    );

    // Output gate: out_en acts without waiting for a clock edge.
    assign dout_vld = rd_vld && out_en;
    assign dout     = dout_vld ? rd_q : '0;

    // R8
    proc_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_proc && !sleep) |=> (acc_lanes_q == '0));
    // R11
    sleep_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !acc_vld_q);
endmodule

// File: tb/test_pipe_burst_sram.sv
`timescale 1ns/1ps
module test_pipe_burst_sram;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        start_proc, start_ctrl, chip_sel, step, order_ilv;
    logic        wr_en, wr_all, out_en, sleep;
    logic [3:0]  lane_en;
    logic [31:0] din, dout;
    logic        dout_vld;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pipe_burst_sram #(.ADDR_W(8)) i_pipe_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .start_proc(start_proc),
        .start_ctrl(start_ctrl), .chip_sel(chip_sel), .step(step),
        .order_ilv(order_ilv), .wr_en(wr_en), .lane_en(lane_en),
        .wr_all(wr_all), .din(din), .out_en(out_en), .sleep(sleep),
        .dout(dout), .dout_vld(dout_vld)
    );

    typedef struct packed {
        logic        sp, sc, cs, stp, we, wa;
        logic [3:0]  le;
        logic [7:0]  ad;
        logic [31:0] dat;
        logic        ev;
        logic [31:0] ed;
        logic [7:0]  req;
    } vec_t;

    // Each row is driven at a falling edge. Its expectation is the output seen
    // one rising edge later, which shows the access of the previous row.
    localparam vec_t TBL [21] = '{
        '{0,1,1,0,0,1,4'h0,8'h10,32'hAAAA0000,0,32'h0,8'd2},         // R2 write 0x10
        '{0,0,0,1,0,1,4'h0,8'h00,32'hAAAA0001,0,32'h0,8'd7},         // R7 0x11
        '{0,0,0,1,0,1,4'h0,8'h00,32'hAAAA0002,0,32'h0,8'd3},         // R3 0x12
        '{0,0,0,1,0,1,4'h0,8'h00,32'hAAAA0003,0,32'h0,8'd3},         // R3 0x13
        '{1,0,1,0,0,0,4'h0,8'h12,32'h0,0,32'h0,8'd6},                // R6 read 0x12
        '{0,0,0,1,0,0,4'h0,8'h00,32'h0,1,32'hAAAA0002,8'd1},         // R1
        '{0,0,0,1,0,0,4'h0,8'h00,32'h0,1,32'hAAAA0003,8'd4},         // R4 wrap to 0x10
        '{0,0,0,1,0,0,4'h0,8'h00,32'h0,1,32'hAAAA0000,8'd4},         // R4
        '{0,0,0,0,0,0,4'h0,8'h00,32'h0,1,32'hAAAA0001,8'd4},         // R4
        '{0,0,0,0,0,0,4'h0,8'h00,32'h0,0,32'h0,8'd3},                // R3 idle
        '{0,1,1,0,1,0,4'h2,8'h11,32'h12345678,0,32'h0,8'd6},         // R6 lane 1
        '{1,0,1,0,1,1,4'hF,8'h11,32'hFFFFFFFF,0,32'h0,8'd6},         // R6 write gives no data
        '{0,0,0,0,0,0,4'h0,8'h00,32'h0,1,32'hAAAA5601,8'd8},         // R8 write ignored
        '{0,1,1,0,0,0,4'hF,8'h10,32'h0,0,32'h0,8'd6},                // R6 lanes w/o wr_en
        '{0,0,0,0,0,0,4'h0,8'h00,32'h0,1,32'hAAAA0000,8'd6},         // R6 unchanged
        '{0,1,1,0,1,0,4'hF,8'h13,32'h0BADF00D,0,32'h0,8'd2},         // R2 all lanes
        '{1,0,1,0,0,0,4'h0,8'h13,32'h0,0,32'h0,8'd2},                // R2
        '{0,0,0,0,0,0,4'h0,8'h00,32'h0,1,32'h0BADF00D,8'd6},         // R6 full word
        '{0,1,0,0,0,0,4'h0,8'h00,32'h0,0,32'h0,8'd9},                // R9 deselect
        '{0,0,0,1,0,0,4'h0,8'h00,32'h0,0,32'h0,8'd9},                // R9
        '{0,0,0,1,0,0,4'h0,8'h00,32'h0,0,32'h0,8'd9}                 // R9 no access
    };

    task automatic idle_in();
        start_proc = 0; start_ctrl = 0; chip_sel = 0; step = 0;
        wr_en = 0; wr_all = 0; lane_en = '0; din = '0; addr = '0;
    endtask

    task automatic check(input logic ev, input logic [31:0] ed, input string req);
        n_vec++;
        if (dout_vld !== ev || (ev && dout !== ed)) begin
            n_bad++;
            $display("FAIL %s: dout_vld=%0b dout=%08h, expected vld=%0b dout=%08h",
                     req, dout_vld, dout, ev, ed);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 0; order_ilv = 0; out_en = 1; sleep = 0;
        repeat (3) @(negedge clk);
        check(0, 32'h0, "R12 reset");
        rst_n = 1;

        for (int i = 0; i < 21; i++) begin
            start_proc = TBL[i].sp; start_ctrl = TBL[i].sc; chip_sel = TBL[i].cs;
            step = TBL[i].stp; wr_en = TBL[i].we; wr_all = TBL[i].wa;
            lane_en = TBL[i].le; addr = TBL[i].ad; din = TBL[i].dat;
            @(negedge clk);
            check(TBL[i].ev, TBL[i].ed, $sformatf("R%0d row %0d", TBL[i].req, i));
        end
        idle_in(); @(negedge clk);

        // R5: interleaved burst from offset 1 reads 1,0,3,2
        order_ilv = 1;
        start_proc = 1; chip_sel = 1; addr = 8'h11; @(negedge clk);
        idle_in(); step = 1; @(negedge clk); check(1, 32'hAAAA5601, "R5 w0");
        @(negedge clk); check(1, 32'hAAAA0000, "R5 w1");
        @(negedge clk); check(1, 32'h0BADF00D, "R5 w2");
        idle_in(); @(negedge clk); check(1, 32'hAAAA0002, "R5 w3");
        @(negedge clk); order_ilv = 0;

        // R11: write during sleep is dropped
        sleep = 1; start_ctrl = 1; chip_sel = 1; wr_all = 1; addr = 8'h10;
        din = 32'hDEADBEEF; @(negedge clk);
        sleep = 0; idle_in(); @(negedge clk); check(0, 32'h0, "R11 no access");
        start_ctrl = 1; chip_sel = 1; addr = 8'h10; @(negedge clk);
        idle_in(); @(negedge clk); check(1, 32'hAAAA0000, "R11 contents kept");

        // R11: counter holds across a sleep cycle with step high
        start_ctrl = 1; chip_sel = 1; addr = 8'h10; @(negedge clk);
        idle_in(); sleep = 1; step = 1; @(negedge clk); check(1, 32'hAAAA0000, "R11 base");
        sleep = 0; @(negedge clk); check(0, 32'h0, "R11 sleep step");
        idle_in(); @(negedge clk); check(1, 32'hAAAA5601, "R11 counter held");

        // R10: output enable gates without a clock edge
        start_proc = 1; chip_sel = 1; addr = 8'h13; @(negedge clk);
        idle_in(); @(negedge clk); check(1, 32'h0BADF00D, "R10 before");
        out_en = 0; #1;
        n_vec++;
        if (dout_vld !== 1'b0 || dout !== 32'h0) begin
            n_bad++;
            $display("FAIL R10: dout_vld=%0b dout=%08h, expected vld=0 dout=00000000",
                     dout_vld, dout);
        end
        out_en = 1; #1; check(1, 32'h0BADF00D, "R10 restored");
        @(negedge clk);

        // R12: reset ends a burst; a later step makes no access
        start_ctrl = 1; chip_sel = 1; addr = 8'h10; @(negedge clk);
        idle_in(); rst_n = 0; @(negedge clk); check(0, 32'h0, "R12 mid-burst");
        rst_n = 1; step = 1; @(negedge clk);
        idle_in(); @(negedge clk); check(0, 32'h0, "R12 burst ended");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule